// File: doc/BRIEF.md
# Serial Identity CRC-8 Checker

This block computes an 8-bit cyclic redundancy check over a 56-bit device identity that a single-wire bus receiver delivers one bit at a time. The identity is an 8-bit family code followed by a 48-bit serial number. Each bit travels least significant bit first, and each bit is qualified by a one-cycle valid strobe. After the 56th identity bit, the running register holds the final check value and a done flag rises.

The eight bits that follow are the check byte sent by the remote device, also least significant bit first. The block assembles them into a byte and compares that byte with the computed value. A clear strobe restarts the whole sequence. The receiver upstream handles wire sampling and timing. This block sees only clean bits.

Top module: `romIdCrcCheck`

## Requirements
- R1: After synchronous reset, or in the cycle after `clear`, `crcOut` is 0x00 and `idDone` and `crcMatch` are 0.
- R2: Each valid identity bit updates the register as follows. Let f = `bitIn` XOR `crcOut[0]`. The register shifts right by one, with 0 entering bit 7. When f is 1, the shifted value is then XORed with 0x8C (bits 7, 3 and 2). A lone 1 bit from zero gives 0x8C; a lone 0 bit gives 0x00.
- R3: A cycle with `bitValid` low changes no output, whatever `bitIn` is.
- R4: `idDone` rises in the cycle after the 56th valid bit and not earlier. At that point `crcOut` equals the check value of the identity, with bit 0 of the family code fed first. For family 0x02 and serial 0x000000_01B81C, that value is 0xA2.
- R5: While `idDone` is high, further valid bits leave `crcOut` unchanged.
- R6: The 8 valid bits after `idDone` are assembled least significant bit first. `crcMatch` rises in the cycle after the 8th of those bits when the byte equals `crcOut`. It stays low while fewer than 8 bits have arrived.
- R7: Valid bits after the check byte is complete are ignored until `clear`, and `crcMatch` holds its value.
- R8: `clear` takes priority over `bitValid` in the same cycle: the bit is discarded and the next valid bit counts as the first identity bit.
- R9: A check byte that differs from `crcOut` in any bit leaves `crcMatch` low after the byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Restart strobe for a new identity |
| bitValid | input | 1 | Qualifies `bitIn` for one cycle |
| bitIn | input | 1 | Received data bit |
| crcOut | output | 8 | Running check register |
| idDone | output | 1 | All 56 identity bits taken |
| crcMatch | output | 1 | Received check byte equals `crcOut` |

## Verification
A single wrong feedback tap or a wrong shift direction corrupts `crcOut` at the first valid 1 bit, so the single-bit cases expose it one cycle after the stimulus. An off-by-one in the identity counter shows up as `idDone` rising one bit early or late. It also leaves a wrong final value after the 56th bit. A fault in the byte assembly or compare appears at `crcMatch` one cycle after the 8th check-byte bit. Correct and corrupted bytes separate it there. The bench also confirms that the complete 64-bit stream leaves a zero residue in its own model. This ties the compare method to the zero-residue property.

// File: rtl/romIdPkg.sv
package romIdPkg;
  typedef struct packed {
    logic clr;
    logic shiftCrc;
    logic shiftByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/romIdCtrl.sv
module romIdCtrl #(
  parameter int ID_BITS = 56,
  parameter int CRC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     bitValid,
  output romIdPkg::ctrlStrobes_t   strobes,
  output logic                     idDone,
  output logic                     byteFull
);
  localparam int ID_CW = $clog2(ID_BITS);
  localparam int BY_CW = $clog2(CRC_W);

  logic [ID_CW-1:0] idCount;
  logic [BY_CW-1:0] byteCount;

  // clear wins over a bit arriving in the same cycle (R8)
  always_comb begin
    strobes.clr       = clear;
    strobes.shiftCrc  = bitValid && !clear && !idDone;
    strobes.shiftByte = bitValid && !clear && idDone && !byteFull;
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clr) begin
      idCount   <= '0;
      byteCount <= '0;
      idDone    <= 1'b0;
      byteFull  <= 1'b0;
    end else begin
      if (strobes.shiftCrc) begin
        idCount <= idCount + 1'b1;
        if (idCount == ID_CW'(ID_BITS - 1)) idDone <= 1'b1;
      end
      if (strobes.shiftByte) begin
        byteCount <= byteCount + 1'b1;
        if (byteCount == BY_CW'(CRC_W - 1)) byteFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/romIdDatapath.sv
module romIdDatapath #(
  parameter int               CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h8C
) (
  input  logic                   clk,
  input  logic                   rst,
  input  romIdPkg::ctrlStrobes_t strobes,
  input  logic                   bitIn,
  input  logic                   byteFull,
  output logic [CRC_W-1:0]       crcReg,
  output logic                   match
);
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] rxByte;
  logic             feedback;

  assign feedback = bitIn ^ crcReg[0];

  // reflected LFSR step: shift right, fold feedback into the tap positions
  genvar gi;
  generate
    for (gi = 0; gi < CRC_W; gi++) begin : g_tap
      if (gi == CRC_W - 1) begin : g_top
        assign crcNext[gi] = POLY[gi] & feedback;
      end else begin : g_mid
        assign crcNext[gi] = crcReg[gi+1] ^ (POLY[gi] & feedback);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobes.clr) begin
      crcReg <= '0;
      rxByte <= '0;
    end else begin
      if (strobes.shiftCrc)  crcReg <= crcNext;
      if (strobes.shiftByte) rxByte <= {bitIn, rxByte[CRC_W-1:1]};
    end
  end

  assign match = byteFull && (rxByte == crcReg);
endmodule

// File: rtl/romIdCrcCheck.sv
module romIdCrcCheck #(
  parameter int ID_BITS = 56,
  parameter int CRC_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bitValid,
  input  logic             bitIn,
  output logic [CRC_W-1:0] crcOut,
  output logic             idDone,
  output logic             crcMatch
);
  romIdPkg::ctrlStrobes_t strobes;
  logic                   byteFull;

  romIdCtrl #(.ID_BITS(ID_BITS), .CRC_W(CRC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .bitValid (bitValid),
    .strobes  (strobes),
    .idDone   (idDone),
    .byteFull (byteFull)
  );

  romIdDatapath #(.CRC_W(CRC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .bitIn    (bitIn),
    .byteFull (byteFull),
    .crcReg   (crcOut),
    .match    (crcMatch)
  );
endmodule

// File: rtl/romIdCrcCheck_chk.sv
module romIdCrcCheck_chk #(
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             bitValid,
  input logic [CRC_W-1:0] crcOut,
  input logic             idDone,
  input logic             crcMatch
);
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crcOut == '0) && !idDone && !crcMatch);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clear && !bitValid) |=> $stable(crcOut) && $stable(idDone) && $stable(crcMatch));

  p_done_needs_bit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(idDone) |-> $past(bitValid) && !$past(clear));

  p_frozen_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    (idDone && !clear) |=> $stable(crcOut) && idDone);

  p_match_after_done_r6: assert property (@(posedge clk) disable iff (rst)
    crcMatch |-> idDone);

  p_match_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (crcMatch && !clear) |=> crcMatch);
endmodule

bind romIdCrcCheck romIdCrcCheck_chk #(.CRC_W(CRC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clear    (clear),
  .bitValid (bitValid),
  .crcOut   (crcOut),
  .idDone   (idDone),
  .crcMatch (crcMatch)
);

// File: tb/test_romIdCrcCheck.sv
module test_romIdCrcCheck;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [7:0] crcOut;
  logic       idDone;
  logic       crcMatch;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  romIdCrcCheck i_romIdCrcCheck (
    .clk(clk), .rst(rst), .clear(clear), .bitValid(bitValid), .bitIn(bitIn),
    .crcOut(crcOut), .idDone(idDone), .crcMatch(crcMatch)
  );

  // bit 56 flags a corrupted check byte; bits 55:0 are the identity, family code in 7:0
  localparam logic [56:0] VEC [6] = '{
    57'h0_00000001B81C02,
    57'h0_123456789ABC28,
    57'h1_00000000000000,
    57'h0_FFFFFFFFFFFFFF,
    57'h1_A5A5A5A5A5A501,
    57'h0_0F1E2D3C4B5A10
  };

  function automatic logic [7:0] refStep(logic [7:0] c, logic b);
    logic f;
    f = b ^ c[0];
    c = c >> 1;
    if (f) c = c ^ 8'h8C;
    return c;
  endfunction

  function automatic logic [7:0] refCrc(logic [55:0] id);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) c = refStep(c, id[i]);
    return c;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    bitIn = ~b;
  endtask

  task automatic doClear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic sendId(logic [55:0] id);
    for (int i = 0; i < 56; i++) sendBit(id[i]);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    logic [7:0] res;
    logic [7:0] tx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(crcOut == 8'h00 && !idDone && !crcMatch, "R1 reset", {5'd0, idDone, crcMatch, 1'b0, crcOut}, 16'h0000);

    // vector table walk: R4 final value, R6 match, R9 corrupted byte
    for (int v = 0; v < 6; v++) begin
      doClear();
      sendId(VEC[v][55:0]);
      exp = refCrc(VEC[v][55:0]);
      check(crcOut == exp && idDone, "R4 final crc", {7'd0, idDone, crcOut}, {8'h01, exp});
      tx = VEC[v][56] ? (exp ^ 8'h10) : exp;
      res = exp;
      for (int i = 0; i < 8; i++) res = refStep(res, tx[i]);
      sendByte(tx);
      if (VEC[v][56]) begin
        check(!crcMatch, "R9 corrupt byte", {15'd0, crcMatch}, 16'h0000);
      end else begin
        check(crcMatch, "R6 match", {15'd0, crcMatch}, 16'h0001);
        check(res == 8'h00, "R6 residue agrees", {8'd0, res}, 16'h0000);
      end
      check(crcOut == exp, "R5 crc frozen", {8'd0, crcOut}, {8'd0, exp});
    end

    // R4 known value
    doClear();
    sendId(56'h00000001B81C02);
    check(crcOut == 8'hA2, "R4 known 0xA2", {8'd0, crcOut}, 16'h00A2);

    // R2 single steps
    doClear();
    sendBit(1'b1);
    check(crcOut == 8'h8C, "R2 one bit", {8'd0, crcOut}, 16'h008C);
    doClear();
    sendBit(1'b0);
    check(crcOut == 8'h00, "R2 zero bit", {8'd0, crcOut}, 16'h0000);
    sendBit(1'b1);
    sendBit(1'b1);
    check(crcOut == refStep(8'h8C, 1'b1), "R2 two ones", {8'd0, crcOut}, {8'd0, refStep(8'h8C, 1'b1)});

    // R3 toggling bitIn with bitValid low
    exp = crcOut;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bitIn = i[0];
    end
    @(negedge clk);
    check(crcOut == exp && !idDone, "R3 idle ignored", {8'd0, crcOut}, {8'd0, exp});

    // R4 not early: 55 bits leave done low
    doClear();
    for (int i = 0; i < 55; i++) sendBit(1'b1);
    check(!idDone, "R4 not early", {15'd0, idDone}, 16'h0000);
    sendBit(1'b1);
    check(idDone, "R4 on 56th", {15'd0, idDone}, 16'h0001);

    // R6 partial byte, R7 extra bits ignored
    exp = refCrc(56'hFFFFFFFFFFFFFF);
    for (int i = 0; i < 7; i++) sendBit(exp[i]);
    check(!crcMatch, "R6 partial byte", {15'd0, crcMatch}, 16'h0000);
    sendBit(exp[7]);
    check(crcMatch, "R6 full byte", {15'd0, crcMatch}, 16'h0001);
    sendByte(~exp);
    check(crcMatch && crcOut == exp, "R7 extra bits ignored", {7'd0, crcMatch, crcOut}, {8'h01, exp});

    // R8 clear and valid together
    @(negedge clk);
    clear = 1'b1;
    bitValid = 1'b1;
    bitIn = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    bitValid = 1'b0;
    check(crcOut == 8'h00 && !idDone && !crcMatch, "R8 clear wins", {8'd0, crcOut}, 16'h0000);
    check(!crcMatch && !idDone, "R1 after clear", {14'd0, idDone, crcMatch}, 16'h0000);
    sendId(56'h123456789ABC28);
    exp = refCrc(56'h123456789ABC28);
    check(idDone && crcOut == exp, "R8 count restarts", {7'd0, idDone, crcOut}, {8'h01, exp});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule